// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block counts activity inside a DDR memory subsystem. The memory controller presents a vector of single-cycle event pulses. Each of the general counters picks one pulse from that vector through a 6-bit event code, and counts it while the counter is enabled and the bank is running. A free-running cycle counter, 56 bits wide, runs alongside them. Global start, stop and clear commands go through one control register. When a general counter wraps, the bank raises a one-cycle overflow pulse on that counter's line, which a separate interrupt block collects.

Software reaches everything through a 32-bit register port with single-cycle read and write strobes. Read data is combinational from the address while the read strobe is high. A general counter is loaded indirectly. The target is first chosen by writing its selector code to a selection register. A write to a shared load register then places the written value in that counter.

Top module: `mc_evt_bank`

## Requirements
- R1: After `rst_n` is released, every general counter, the cycle counter, the run flag, all event-select words and the selection register read as zero.
- R2: A write to the control word at 0xC00 with bit 0 set starts the bank and one with bit 1 set stops it. The run flag reads back in bit 0 of the state word at 0xC04 from the cycle after the write. Control bits read back as zero.
- R3: When start and stop are written together, the bank ends up stopped.
- R4: A write to 0xC00 with bit 2 set clears all general counters and the cycle counter and stops the bank, all at the same edge, even if bit 0 is also set. Event-select words keep their contents.
- R5: Counter n is configured by the byte at bits [8*(n%4)+7 : 8*(n%4)] of the select word at 0xC68 + 4*(n/4). In that byte, bit 7 enables the counter and bits 5:0 name the bit of `evt_pulse` to count. The counter rises by one at every clock edge where that bit is high, the counter is enabled and the bank is running.
- R6: A counter whose enable bit is clear, or any counter while the bank is stopped, keeps its value whatever `evt_pulse` does.
- R7: General counter n reads at 0xC78 + 4*n.
- R8: The cycle counter rises by one at every edge while the bank runs and holds while it is stopped. Its low 32 bits read at 0xC14, and bits 55:32 read at 0xC10 with bits 31:24 of that word zero.
- R9: The selection register at 0xC08 is readable. While it holds 19 + n, a write to 0xC0C loads the written value into counter n. With any other value, such as 0 or 19 + 16, the write changes no counter. 0xC0C reads as zero.
- R10: When counter n rises past 0xFFFFFFFF it becomes 0 and keeps counting. `ovf_pulse[n]` is high for exactly the one cycle in which the counter reads 0 after the wrap.
- R11: Writes to undecoded addresses change nothing. Reads of undecoded addresses return zero, and `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| evt_pulse | input | 64 | Single-cycle event pulses from the memory controller |
| ovf_pulse | output | 16 | Per-counter wrap pulses to the interrupt block |

## Verification
The bench builds the bank with its default parameters: sixteen 32-bit counters, a 56-bit cycle counter and a 64-line event vector. The counter-load path brings the 32-bit wrap within reach of a short run, so the overflow pulse and the count that follows it are exercised directly. The carry from the low to the high word of the cycle counter needs about 2^32 cycles. It is therefore covered by the step-by-one property on the cycle counter and not by a directed read.

// File: rtl/mcevt_pkg.sv
package mcevt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_STATE = 12'hC04;
  localparam logic [ADDR_W-1:0] OFS_TSEL  = 12'hC08;
  localparam logic [ADDR_W-1:0] OFS_PRE   = 12'hC0C;
  localparam logic [ADDR_W-1:0] OFS_CYCHI = 12'hC10;
  localparam logic [ADDR_W-1:0] OFS_CYCLO = 12'hC14;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 12'hC68;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 12'hC78;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLEAR = 2;

  localparam int TSEL_BASE = 19;
  localparam int FIELD_W   = 8;
  localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;
endpackage

// File: rtl/mcevt_runctl.sv
module mcevt_runctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [2:0] cmd,
  output logic       run_q,
  output logic       clr
);
  import mcevt_pkg::*;

  logic run_d;

  always_comb begin
    run_d = run_q;
    if (cmd_we) begin
      if (cmd[CMD_CLEAR] || cmd[CMD_STOP]) run_d = 1'b0;
      else if (cmd[CMD_START])             run_d = 1'b1;
    end
  end

  assign clr = cmd_we & cmd[CMD_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/mcevt_gcnt.sv
module mcevt_gcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic         ovf_q
);
  logic [W-1:0] cnt_d;
  logic         ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      ovf_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/mcevt_cyc.sv
module mcevt_cyc #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cyc_q
);
  logic [W-1:0] cyc_d;

  always_comb begin
    cyc_d = cyc_q;
    if (clr)      cyc_d = '0;
    else if (run) cyc_d = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end
endmodule

// File: rtl/mc_evt_bank.sv
module mc_evt_bank #(
  parameter int NUM_CTR = 16,
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 56,
  parameter int EVT_W   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [mcevt_pkg::ADDR_W-1:0] addr,
  input  logic [mcevt_pkg::DATA_W-1:0] wdata,
  output logic [mcevt_pkg::DATA_W-1:0] rdata,
  input  logic [EVT_W-1:0]           evt_pulse,
  output logic [NUM_CTR-1:0]         ovf_pulse
);
  import mcevt_pkg::*;

  localparam int SEL_WORDS = (NUM_CTR + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int CYC_HI_W  = CYC_W - DATA_W;
  localparam int CODE_W    = 6;

  logic                 run_q, clr;
  logic                 ctrl_we, tsel_we, pre_we;
  logic [SEL_WORDS-1:0] sel_we;
  logic [DATA_W-1:0]    sel_q [SEL_WORDS];
  logic [DATA_W-1:0]    sel_d [SEL_WORDS];
  logic [7:0]           tsel_q, tsel_d;
  logic [CNT_W-1:0]     cnt_q [NUM_CTR];
  logic [CYC_W-1:0]     cyc_q;
  logic [DATA_W-1:0]    rdata_c;

  assign ctrl_we = wr_en && (addr == OFS_CTRL);
  assign tsel_we = wr_en && (addr == OFS_TSEL);
  assign pre_we  = wr_en && (addr == OFS_PRE);

  mcevt_runctl u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_we (ctrl_we),
    .cmd    (wdata[2:0]),
    .run_q  (run_q),
    .clr    (clr)
  );

  mcevt_cyc #(.W(CYC_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .run   (run_q),
    .cyc_q (cyc_q)
  );

  // Selection register next state and storage
  always_comb begin
    tsel_d = tsel_q;
    if (tsel_we) tsel_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsel_q <= '0;
    else        tsel_q <= tsel_d;
  end

  // Event-select words
  for (genvar k = 0; k < SEL_WORDS; k++) begin : g_sel
    assign sel_we[k] = wr_en &&
                       (addr == ADDR_W'(OFS_SEL + (k * (DATA_W / 8))));
    always_comb begin
      sel_d[k] = sel_q[k];
      if (sel_we[k]) sel_d[k] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[k] <= '0;
      else        sel_q[k] <= sel_d[k];
    end
  end

  // General counters
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_cnt
    localparam int WI = i / FIELDS_PER_WORD;
    localparam int LO = FIELD_W * (i % FIELDS_PER_WORD);
    logic              en_i, inc_i, load_i;
    logic [CODE_W-1:0] code_i;

    assign en_i   = sel_q[WI][LO + 7];
    assign code_i = sel_q[WI][LO +: CODE_W];
    assign inc_i  = run_q && en_i && evt_pulse[code_i];
    assign load_i = pre_we && (tsel_q == 8'(TSEL_BASE + i));

    mcevt_gcnt #(.W(CNT_W)) u_gcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (load_i),
      .load_val (wdata[CNT_W-1:0]),
      .inc      (inc_i),
      .cnt_q    (cnt_q[i]),
      .ovf_q    (ovf_pulse[i])
    );
  end

  // Read mux
  always_comb begin
    rdata_c = '0;
    if (rd_en) begin
      if (addr == OFS_STATE) rdata_c = {{(DATA_W-1){1'b0}}, run_q};
      if (addr == OFS_TSEL)  rdata_c = {{(DATA_W-8){1'b0}}, tsel_q};
      if (addr == OFS_CYCLO) rdata_c = cyc_q[DATA_W-1:0];
      if (addr == OFS_CYCHI) rdata_c = DATA_W'(cyc_q[CYC_W-1 -: CYC_HI_W]);
      for (int k = 0; k < SEL_WORDS; k++)
        if (addr == ADDR_W'(OFS_SEL + (k * (DATA_W / 8)))) rdata_c = sel_q[k];
      for (int n = 0; n < NUM_CTR; n++)
        if (addr == ADDR_W'(OFS_CNT + (n * (DATA_W / 8))))
          rdata_c = DATA_W'(cnt_q[n]);
    end
  end

  assign rdata = rdata_c;
endmodule

// File: rtl/mcevt_bank_chk.sv
module mcevt_bank_chk #(
  parameter int NUM_CTR = 16,
  parameter int CYC_W   = 56
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [mcevt_pkg::ADDR_W-1:0] addr,
  input logic [mcevt_pkg::DATA_W-1:0] wdata,
  input logic [mcevt_pkg::DATA_W-1:0] rdata,
  input logic [NUM_CTR-1:0]           ovf_pulse,
  input logic                         run_q,
  input logic [CYC_W-1:0]             cyc_q
);
  import mcevt_pkg::*;

  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == OFS_CTRL);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[0] && !wdata[1] && !wdata[2] |=> run_q); // R2

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[1] |=> !run_q); // R3

  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[2] |=> !run_q && (cyc_q == '0)); // R4

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !(ctl_wr && wdata[2]) |=> cyc_q == CYC_W'($past(cyc_q) + 1'b1)); // R8

  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cyc_q) || (cyc_q == '0)); // R8

  AST_CYC_HI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == OFS_CYCHI) |-> rdata[31:24] == 8'h00); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_pulse) |-> $past(run_q)); // R10

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0); // R11
endmodule

bind mc_evt_bank mcevt_bank_chk #(.NUM_CTR(NUM_CTR), .CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .ovf_pulse (ovf_pulse),
  .run_q     (run_q),
  .cyc_q     (cyc_q)
);

// File: tb/mc_evt_bank_test.sv
`timescale 1ns/1ps
module mc_evt_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [63:0] evt_pulse;
  logic [15:0] ovf_pulse;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mc_evt_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .ovf_pulse(ovf_pulse)
  );

  localparam logic [11:0] A_CTRL = 12'hC00, A_STATE = 12'hC04, A_TSEL = 12'hC08,
                          A_PRE = 12'hC0C, A_CYCHI = 12'hC10, A_CYCLO = 12'hC14,
                          A_SEL = 12'hC68;

  function automatic logic [11:0] a_cnt(int n);
    return 12'(12'hC78 + 4 * n);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // All tasks start and end on a falling edge and span one rising edge.
  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0; addr = '0;
    @(negedge clk);
  endtask

  task automatic pulse(int idx);
    evt_pulse = 64'd1 << idx;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STATE, d);    chk("R1 run flag", d, 0);
    rd(a_cnt(0), d);   chk("R1 counter0", d, 0);
    rd(a_cnt(15), d);  chk("R1 counter15", d, 0);
    rd(A_CYCLO, d);    chk("R1 cycle low", d, 0);
    rd(A_SEL + 4, d);  chk("R1 select word1", d, 0);
    rd(A_TSEL, d);     chk("R1 selection reg", d, 0);
  endtask

  task automatic t_run_ctl();
    logic [31:0] d;
    wr(A_CTRL, 32'h1); rd(A_STATE, d); chk("R2 start", d, 1);
    rd(A_CTRL, d);     chk("R2 control reads zero", d, 0);
    wr(A_CTRL, 32'h2); rd(A_STATE, d); chk("R2 stop", d, 0);
    wr(A_CTRL, 32'h3); rd(A_STATE, d); chk("R3 start+stop from idle", d, 0);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h3); rd(A_STATE, d); chk("R3 start+stop while running", d, 0);
  endtask

  task automatic t_cycle();
    logic [31:0] d;
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    rd(A_CYCLO, d);   chk("R8 cycle at start", d, 0);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h2);
    rd(A_CYCLO, d);   chk("R8 cycle after run", d, 7);
    rd(A_CYCLO, d);   chk("R8 cycle holds when stopped", d, 7);
    rd(A_CYCHI, d);   chk("R8 cycle high word", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(A_CTRL, 32'h4);
    wr(A_SEL + 0,  32'hBF05_8585);
    wr(A_SEL + 4,  32'h0000_8900);
    wr(A_SEL + 12, 32'h8000_0000);
    wr(A_CTRL, 32'h1);
    repeat (3) pulse(5);
    @(negedge clk);
    repeat (2) pulse(9);
    pulse(63);
    repeat (4) pulse(0);
    wr(A_CTRL, 32'h2);
    pulse(5);
    rd(a_cnt(0), d);  chk("R5 counter0 event5", d, 3);
    rd(a_cnt(1), d);  chk("R5 counter1 shares event5", d, 3);
    rd(a_cnt(2), d);  chk("R6 disabled counter2", d, 0);
    rd(a_cnt(3), d);  chk("R5 counter3 event63", d, 1);
    rd(a_cnt(4), d);  chk("R6 unconfigured counter4", d, 0);
    rd(a_cnt(5), d);  chk("R7 counter5 event9", d, 2);
    rd(a_cnt(15), d); chk("R7 counter15 event0", d, 4);
    rd(A_SEL, d);     chk("R5 select word readback", d, 32'hBF05_8585);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    pulse(5);
    rd(a_cnt(0), d);  chk("R5 counter0 resumes", d, 4);
    wr(A_CTRL, 32'h4);
    rd(a_cnt(0), d);  chk("R4 counter0 cleared", d, 0);
    rd(a_cnt(15), d); chk("R4 counter15 cleared", d, 0);
    rd(A_CYCLO, d);   chk("R4 cycle cleared", d, 0);
    rd(A_STATE, d);   chk("R4 stopped", d, 0);
    rd(A_SEL, d);     chk("R4 select kept", d, 32'hBF05_8585);
    wr(A_CTRL, 32'h5);
    rd(A_STATE, d);   chk("R4 clear beats start", d, 0);
  endtask

  task automatic t_preload();
    logic [31:0] d;
    wr(A_TSEL, 32'd26);
    rd(A_TSEL, d);    chk("R9 selection readback", d, 26);
    wr(A_PRE, 32'h1234_5678);
    rd(a_cnt(7), d);  chk("R9 load counter7", d, 32'h1234_5678);
    rd(a_cnt(6), d);  chk("R9 neighbour untouched", d, 0);
    wr(A_TSEL, 32'd0);
    wr(A_PRE, 32'h0000_AAAA);
    rd(a_cnt(7), d);  chk("R9 no load when deselected", d, 32'h1234_5678);
    wr(A_TSEL, 32'd35);
    wr(A_PRE, 32'h0000_BBBB);
    rd(a_cnt(15), d); chk("R9 out-of-range selector", d, 0);
    rd(A_PRE, d);     chk("R9 load register reads zero", d, 0);
    wr(A_TSEL, 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wr(A_SEL + 4, 32'h0000_8982);
    wr(A_TSEL, 32'd23);
    wr(A_PRE, 32'hFFFF_FFFE);
    wr(A_TSEL, 32'd0);
    wr(A_CTRL, 32'h1);
    pulse(2);
    chk("R10 no pulse before wrap", 32'(ovf_pulse), 0);
    rd(a_cnt(4), d);  chk("R10 counter4 at max", d, 32'hFFFF_FFFF);
    pulse(2);
    chk("R10 wrap pulse", 32'(ovf_pulse), 32'h0000_0010);
    rd(a_cnt(4), d);  chk("R10 counter4 wrapped", d, 0);
    chk("R10 pulse lasts one cycle", 32'(ovf_pulse), 0);
    pulse(2);
    rd(a_cnt(4), d);  chk("R10 counts on after wrap", d, 1);
  endtask

  task automatic t_undecoded();
    logic [31:0] d;
    wr(12'hC50, 32'h0000_0004);
    wr(12'hC18, 32'h0000_0002);
    rd(A_STATE, d);   chk("R11 stray writes ignored", d, 1);
    rd(a_cnt(4), d);  chk("R11 counter4 untouched", d, 1);
    rd(12'hC50, d);   chk("R11 undecoded read", d, 0);
    #1 chk("R11 idle rdata", rdata, 0);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; evt_pulse = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_ctl();
    t_cycle();
    t_count();
    t_clear();
    t_preload();
    t_overflow();
    t_undecoded();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule